// File: doc/BRIEF.md
# Integrity Signature Scan Capture

This block is a scan-chain segment that carries a replica's integrity status off the chip through the manufacturing test path. An anomaly detector pulses an alarm input. The pulse is held in a signature register, which reads all zeros while the replica is trusted and all ones once any alarm has been seen. At the start of each checkpoint interval a clear returns the register to zeros.

A controller drives the chain with two inputs, a capture/shift select and a shift enable. A capture copies the whole signature into the scan cells on a single clock edge. Each shift then moves the cells one place toward the serial output, with bit 0 leaving first, while the serial test data input fills the chain from the far end. A done flag reports that a complete 32-bit word has been shifted out since the last capture.

Top module: `sig_scan_capture`

## Requirements
- R1: While reset is high, and in the first cycle after it, the serial output and the done flag are low and every scan cell holds 0.
- R2: An alarm pulse on any clock edge sets all 32 signature bits to 1. The bits stay at 1 through any number of later cycles until a clear is applied, so a later capture loads all ones.
- R3: A clear with no alarm in the same cycle returns the signature to all zeros on the next edge. When a clear and an alarm arrive in the same cycle, the alarm wins and the signature is all ones.
- R4: With the capture select high (1 = capture, 0 = serial path), all 32 cells load the signature in parallel on one edge. The shift enable has no effect in that cycle.
- R5: With the capture select low and the shift enable high, each edge moves every cell one place toward the output. The serial output always shows cell 0, so bit 0 leaves first. With both inputs low, the chain holds its contents.
- R6: The serial input enters at cell 31. After 32 shifts the chain holds the last 32 serial input bits, and the first of those bits sits in cell 0.
- R7: The done flag goes high in the cycle that follows the 32nd shift after a capture, and not before. It stays high until the next capture, which lowers it on that capture's edge. It stays low after reset until a capture has been made.
- R8: A capture loads the signature value as it stood before the edge. An alarm in the same cycle as a capture reaches the chain only at a later capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alarm_i | input | 1 | Anomaly alarm pulse |
| clear_i | input | 1 | Start of a new checkpoint interval; clears the signature |
| capture_i | input | 1 | 1 = parallel capture of the signature, 0 = serial path |
| shift_en_i | input | 1 | Shift the chain one place when not capturing |
| tdi_i | input | 1 | Serial test data in, enters at cell 31 |
| tdo_o | output | 1 | Serial test data out, shows cell 0 |
| shift_done_o | output | 1 | A full word has been shifted since the last capture |

## Verification
The bench applies a clear and an alarm in the same cycle. A design that gives the clear priority would let an alarmed replica report clean for the rest of the interval. It also applies an alarm and a capture in the same cycle: a design that forwards the new alarm into the chain would show ones one capture early, and the first word would not match the signature as it stood before the edge. The bench holds the shift enable high during a capture, so a chain that shifts while it captures would present a word rotated by one place. It also counts shifts to 31, 32 and 33, so a done flag that rises one shift early or late, or that is not lowered by a new capture, shows up at once.

// File: rtl/sig_scan_pkg.sv
package sig_scan_pkg;

    localparam int DEF_SIG_W = 32;

    typedef enum logic [1:0] {
        OP_HOLD    = 2'd0,
        OP_SHIFT   = 2'd1,
        OP_CAPTURE = 2'd2
    } chain_op_e;

    // capture dominates; shift only on the serial path
    function automatic chain_op_e decode_op(input logic capture, input logic shift_en);
        if (capture)       return OP_CAPTURE;
        else if (shift_en) return OP_SHIFT;
        else               return OP_HOLD;
    endfunction

endpackage

// File: rtl/sig_alarm_latch.sv
module sig_alarm_latch
    import sig_scan_pkg::*;
#(
    parameter int SIG_W = DEF_SIG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alarm_i,
    input  logic             clear_i,
    output logic [SIG_W-1:0] sig_o
);
    // alarm takes precedence over the interval clear
    always_ff @(posedge clk) begin
        if (rst)          sig_o <= '0;
        else if (alarm_i) sig_o <= '1;
        else if (clear_i) sig_o <= '0;
    end
endmodule

// File: rtl/sig_scan_ctrl.sv
module sig_scan_ctrl
    import sig_scan_pkg::*;
#(
    parameter int SIG_W = DEF_SIG_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      capture_i,
    input  logic      shift_en_i,
    output chain_op_e op_o,
    output logic      done_o
);
    localparam int CNT_W = $clog2(SIG_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(SIG_W);

    logic [CNT_W-1:0] cnt_q;
    logic             armed_q;

    assign op_o = decode_op(capture_i, shift_en_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (op_o == OP_CAPTURE) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
        end else if (op_o == OP_SHIFT && armed_q && cnt_q != FULL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = armed_q && (cnt_q == FULL);
endmodule

// File: rtl/sig_scan_chain.sv
module sig_scan_chain
    import sig_scan_pkg::*;
#(
    parameter int SIG_W = DEF_SIG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  chain_op_e        op_i,
    input  logic [SIG_W-1:0] sig_i,
    input  logic             tdi_i,
    output logic [SIG_W-1:0] cells_o
);
    logic [SIG_W-1:0] ser_in;

    for (genvar i = 0; i < SIG_W; i++) begin : g_cell
        if (i == SIG_W - 1) begin : g_head
            assign ser_in[i] = tdi_i;
        end else begin : g_link
            assign ser_in[i] = cells_o[i+1];
        end

        // per-cell mux: signature bit or serial neighbour
        always_ff @(posedge clk) begin
            if (rst) begin
                cells_o[i] <= 1'b0;
            end else begin
                case (op_i)
                    OP_CAPTURE: cells_o[i] <= sig_i[i];
                    OP_SHIFT:   cells_o[i] <= ser_in[i];
                    default:    cells_o[i] <= cells_o[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/sig_scan_capture.sv
module sig_scan_capture
    import sig_scan_pkg::*;
#(
    parameter int SIG_W = DEF_SIG_W
) (
    input  logic clk,
    input  logic rst,
    input  logic alarm_i,
    input  logic clear_i,
    input  logic capture_i,
    input  logic shift_en_i,
    input  logic tdi_i,
    output logic tdo_o,
    output logic shift_done_o
);
    logic [SIG_W-1:0] sig_q;
    logic [SIG_W-1:0] chain_q;
    chain_op_e        op;

    sig_alarm_latch #(.SIG_W(SIG_W)) u_latch (
        .clk(clk), .rst(rst), .alarm_i(alarm_i), .clear_i(clear_i), .sig_o(sig_q)
    );

    sig_scan_ctrl #(.SIG_W(SIG_W)) u_ctrl (
        .clk(clk), .rst(rst), .capture_i(capture_i), .shift_en_i(shift_en_i),
        .op_o(op), .done_o(shift_done_o)
    );

    sig_scan_chain #(.SIG_W(SIG_W)) u_chain (
        .clk(clk), .rst(rst), .op_i(op), .sig_i(sig_q), .tdi_i(tdi_i), .cells_o(chain_q)
    );

    assign tdo_o = chain_q[0];
endmodule

// File: rtl/sig_scan_capture_chk.sv
module sig_scan_capture_chk #(
    parameter int SIG_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             alarm_i,
    input logic             clear_i,
    input logic             capture_i,
    input logic             shift_en_i,
    input logic             tdo_o,
    input logic             shift_done_o,
    input logic [SIG_W-1:0] sig_q,
    input logic [SIG_W-1:0] chain_q
);
    a_r1_reset_clean: assert property (@(posedge clk)
        rst |=> (chain_q == '0 && !shift_done_o && !tdo_o));

    a_r2_alarm_sets: assert property (@(posedge clk) disable iff (rst)
        alarm_i |=> (&sig_q));

    a_r2_alarm_holds: assert property (@(posedge clk) disable iff (rst)
        ((&sig_q) && !clear_i) |=> (&sig_q));

    a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (clear_i && !alarm_i) |=> (sig_q == '0));

    a_r4_capture_load: assert property (@(posedge clk) disable iff (rst)
        capture_i |=> (chain_q == $past(sig_q)));

    a_r5_shift_out: assert property (@(posedge clk) disable iff (rst)
        (!capture_i && shift_en_i) |=> (tdo_o == $past(chain_q[1])));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!capture_i && !shift_en_i) |=> $stable(chain_q));

    a_r7_done_drop: assert property (@(posedge clk) disable iff (rst)
        capture_i |=> !shift_done_o);

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (shift_done_o && !capture_i) |=> shift_done_o);

    a_r8_capture_old: assert property (@(posedge clk) disable iff (rst)
        (capture_i && alarm_i && sig_q == '0) |=> (chain_q == '0));
endmodule

bind sig_scan_capture sig_scan_capture_chk #(.SIG_W(SIG_W)) u_chk (
    .clk(clk), .rst(rst), .alarm_i(alarm_i), .clear_i(clear_i),
    .capture_i(capture_i), .shift_en_i(shift_en_i), .tdo_o(tdo_o),
    .shift_done_o(shift_done_o), .sig_q(sig_q), .chain_q(chain_q)
);

// File: tb/sim_sig_scan_capture.sv
module sim_sig_scan_capture;
    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alarm_i = 0, clear_i = 0, capture_i = 0, shift_en_i = 0, tdi_i = 0;
    logic tdo_o, shift_done_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // reference model state
    bit m_sig;
    bit m_q[$];
    int m_shifts;

    always #2 clk = ~clk;

    sig_scan_capture #(.SIG_W(W)) u0 (
        .clk(clk), .rst(rst), .alarm_i(alarm_i), .clear_i(clear_i),
        .capture_i(capture_i), .shift_en_i(shift_en_i), .tdi_i(tdi_i),
        .tdo_o(tdo_o), .shift_done_o(shift_done_o)
    );

    task automatic model_reset();
        m_sig = 0;
        m_q.delete();
        for (int i = 0; i < W; i++) m_q.push_back(1'b0);
        m_shifts = -1;
    endtask

    task automatic compare(string tag);
        bit exp_done;
        exp_done = (m_shifts >= W);
        checks++;
        if (tdo_o !== m_q[0]) begin
            errors++;
            $display("FAIL %s tdo actual=%b expected=%b at %0t", tag, tdo_o, m_q[0], $time);
        end
        checks++;
        if (shift_done_o !== exp_done) begin
            errors++;
            $display("FAIL %s done actual=%b expected=%b at %0t", tag, shift_done_o, exp_done, $time);
        end
    endtask

    // called at a negedge: drive, take one edge, update model, compare
    task automatic cyc(bit cap, bit sh, bit td, bit al, bit cl, string tag);
        capture_i = cap; shift_en_i = sh; tdi_i = td; alarm_i = al; clear_i = cl;
        @(posedge clk);
        if (rst) begin
            model_reset();
        end else begin
            if (cap) begin
                for (int i = 0; i < W; i++) m_q[i] = m_sig;
                m_shifts = 0;
            end else if (sh) begin
                void'(m_q.pop_front());
                m_q.push_back(td);
                if (m_shifts >= 0 && m_shifts < W) m_shifts++;
            end
            if (al) m_sig = 1;
            else if (cl) m_sig = 0;
        end
        @(negedge clk);
        compare(tag);
    endtask

    task automatic shift_word(logic [W-1:0] pat, string tag);
        for (int i = 0; i < W; i++) cyc(0, 1, pat[i], 0, 0, tag);
    endtask

    initial begin
        model_reset();
        @(negedge clk);
        // R1: reset state
        cyc(0, 1, 1, 1, 0, "R1");
        cyc(1, 1, 1, 0, 0, "R1");
        rst = 0;
        compare("R1");
        cyc(0, 0, 0, 0, 0, "R1");
        // R7: no capture yet, shifting never raises done
        shift_word(32'hFFFF_0000, "R7");
        // R4, R5: capture clean signature, shift a pattern in
        cyc(1, 0, 0, 0, 0, "R4");
        shift_word(32'hA5C3_1E77, "R6");
        // R5: hold cycles interleaved with shifts, reading pattern out
        for (int i = 0; i < 8; i++) begin
            cyc(0, 0, 1, 0, 0, "R5");
            cyc(0, 1, i[0], 0, 0, "R5");
        end
        shift_word(32'h0F0F_3C3C, "R6");
        // R2: alarm pulse, idle, then capture still sees all ones
        cyc(0, 0, 0, 1, 0, "R2");
        for (int i = 0; i < 5; i++) cyc(0, 0, 0, 0, 0, "R2");
        cyc(1, 0, 0, 0, 0, "R2");
        shift_word(32'h1234_5678, "R2");
        // R3: clear alone, then clear with alarm together
        cyc(0, 0, 0, 0, 1, "R3");
        cyc(1, 0, 0, 0, 0, "R3");
        shift_word(32'hDEAD_BEEF, "R3");
        cyc(0, 0, 0, 1, 1, "R3");
        cyc(1, 0, 0, 0, 0, "R3");
        shift_word(32'h0000_0001, "R3");
        // R4: shift enable ignored while capturing
        cyc(0, 0, 0, 0, 1, "R4");
        shift_word(32'hCAFE_F00D, "R4");
        cyc(1, 1, 1, 0, 0, "R4");
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0, 0, "R4");
        // R8: alarm in the same cycle as capture is not seen by that capture
        cyc(1, 0, 0, 1, 0, "R8");
        shift_word(32'h8000_0000, "R8");
        cyc(1, 0, 0, 0, 0, "R8");
        shift_word(32'h7777_1111, "R8");
        // R7: done window, restart mid-count, 31/32/33 shifts
        cyc(0, 0, 0, 0, 1, "R7");
        cyc(1, 0, 0, 0, 0, "R7");
        for (int i = 0; i < 20; i++) cyc(0, 1, 1, 0, 0, "R7");
        cyc(1, 1, 0, 0, 0, "R7");
        for (int i = 0; i < 33; i++) cyc(0, 1, i[1], 0, 0, "R7");
        cyc(0, 0, 0, 0, 0, "R7");
        cyc(1, 0, 0, 0, 0, "R7");
        cyc(0, 0, 0, 0, 0, "R7");
        // R1: reset mid-operation returns to clean state
        cyc(0, 0, 0, 1, 0, "R1");
        rst = 1;
        cyc(0, 1, 1, 0, 0, "R1");
        rst = 0;
        cyc(0, 0, 0, 0, 0, "R1");
        cyc(1, 0, 0, 0, 0, "R1");
        shift_word(32'h5555_AAAA, "R1");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule